// File: doc/BRIEF.md
# Sleep State Sequencer

This block steps a system between the working state, the sleeping states S1 through S4 and soft-off (S5). Software selects a target with a 3-bit sleep type and launches the transition with a one-cycle sleep-enable strobe. The sequencer then asks the processor to halt and waits for its acknowledgement. Once the acknowledgement arrives, it reports the held sleeping state to the rail controller and stays there until an enabled wake source fires or a forced-off request arrives.

A sticky wake-status bit records every wake taken from a sleeping state. Only a wake seen after the processor has acknowledged the halt can set it. On exit the block gives a single-cycle indication: a direct resume when it leaves S1, or a reset-vector restart when it leaves S2 to S5.

An alarm wake input is gated by the sleep depth, by an S4 permission input and by a battery-low input. A forced-off request moves the block straight to soft-off from any state. If the processor does not acknowledge the halt within a parameterized number of cycles, the block drops back to working and raises an error flag.

Top module: `sleep_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0 and the block is in the working state.
- R2: In the working state, a `slp_go_i` pulse with `slp_type_i` from 1 to 5 (value n selects Sn) raises `halt_req_o` on the next cycle. `asleep_o` and `pwr_state_o` stay 0 while the acknowledgement is pending.
- R3: A `slp_go_i` pulse with `slp_type_i` equal to 0, 6 or 7 is ignored and the block stays working. A pulse outside the working state is also ignored. Sleep-enable is a strobe and is never held.
- R4: A `halt_ack_i` seen while waiting makes `asleep_o` 1 and `pwr_state_o` equal to the selected type on the next cycle. `halt_req_o` stays 1 while asleep.
- R5: A wake event in the working state or while waiting for the acknowledgement does not set `wak_sts_o`. It also does not end the wait.
- R6: While asleep, any source with both `wake_ev_i[i]` and `wake_en_i[i]` high sets `wak_sts_o` on the next cycle. On that same cycle `asleep_o`, `halt_req_o` and `pwr_state_o` return to 0. A source whose enable bit is 0 has no effect.
- R7: The exit cycle pulses `resume_o` for exactly one cycle when leaving S1, or `restart_o` for exactly one cycle when leaving S2 to S5. The two pulses are never high together. The block is working on the cycle after the pulse.
- R8: `wak_sts_o` is cleared only by `wak_clr_i` = 1. If a wake set and a clear fall in the same cycle, the set wins.
- R9: `override_i` moves the block, from any state, to asleep with `pwr_state_o` = 5 on the next cycle. No wake-status set and no exit pulse come from that cycle.
- R10: `alarm_i` with `alarm_en_i` wakes the block from S1 to S3. It wakes S4 only when `alarm_s4_ok_i` is 1, and never wakes S5. `batt_low_i` = 1 blocks the alarm in every state.
- R11: If no acknowledgement arrives within TMO_CYC cycles of waiting, `halt_req_o` falls after exactly TMO_CYC cycles and the block returns to working with `tmo_err_o` = 1. The flag stays set until the next accepted sleep request clears it.
- R12: Moving between two sleep states goes through a wake. After the exit cycle, a new sleep request with a different type is accepted as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_type_i | input | 3 | Requested sleep type, n selects Sn |
| slp_go_i | input | 1 | Sleep-enable strobe |
| wake_ev_i | input | NW | Wake event per source |
| wake_en_i | input | NW | Wake enable per source |
| alarm_i | input | 1 | Alarm wake event |
| alarm_en_i | input | 1 | Alarm wake enable |
| alarm_s4_ok_i | input | 1 | Permit alarm wake from S4 |
| batt_low_i | input | 1 | Battery low, blocks alarm wake |
| override_i | input | 1 | Forced-off request |
| halt_ack_i | input | 1 | Processor has stopped |
| wak_clr_i | input | 1 | Write-1-to-clear for wake status |
| halt_req_o | output | 1 | Ask processor to halt / hold halted |
| asleep_o | output | 1 | Sleeping state is held |
| pwr_state_o | output | 3 | Held sleep state for rail control, 0 when not asleep |
| wak_sts_o | output | 1 | Sticky wake status |
| resume_o | output | 1 | One-cycle direct-resume indication |
| restart_o | output | 1 | One-cycle reset-vector restart indication |
| tmo_err_o | output | 1 | Halt acknowledgement timed out |

## Verification
Each of the four internal states has its own pattern on the registered outputs. Working shows no request, waiting shows the halt request alone, asleep adds `asleep_o` and a non-zero `pwr_state_o`, and exit shows one pulse. A wrong state or a wrong latched type therefore appears at the ports on the very next cycle. A counter that is off by one in the timeout path shows up as a halt request one cycle too long or too short. A wrong wake qualification shows up as `wak_sts_o` set or not set one cycle after the event.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_WORK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_EXIT  = 2'd3
  } seq_st_e;

  localparam logic [2:0] SX_S1 = 3'd1;
  localparam logic [2:0] SX_S3 = 3'd3;
  localparam logic [2:0] SX_S4 = 3'd4;
  localparam logic [2:0] SX_S5 = 3'd5;

  // a sleep type is accepted only for S1..S5
  function automatic logic type_ok(input logic [2:0] t);
    return (t >= SX_S1) && (t <= SX_S5);
  endfunction

  // depth gating of the alarm wake
  function automatic logic alarm_depth_ok(input logic [2:0] t, input logic s4ok);
    return ((t >= SX_S1) && (t <= SX_S3)) || ((t == SX_S4) && s4ok);
  endfunction

endpackage

// File: rtl/sleep_seq_wake.sv
module sleep_seq_wake
  import sleep_seq_pkg::*;
#(
  parameter int unsigned NW = 4
) (
  input  logic [NW-1:0] wake_ev_i,
  input  logic [NW-1:0] wake_en_i,
  input  logic          alarm_i,
  input  logic          alarm_en_i,
  input  logic          alarm_s4_ok_i,
  input  logic          batt_low_i,
  input  logic [2:0]    tgt_i,
  output logic          wake_hit_o
);

  logic [NW-1:0] masked;
  logic          alarm_hit;

  for (genvar g = 0; g < NW; g++) begin : g_src
    assign masked[g] = wake_ev_i[g] & wake_en_i[g];
  end

  always_comb begin
    alarm_hit  = alarm_i & alarm_en_i & ~batt_low_i & alarm_depth_ok(tgt_i, alarm_s4_ok_i);
    wake_hit_o = (|masked) | alarm_hit;
  end

endmodule

// File: rtl/sleep_seq_tmo.sv
module sleep_seq_tmo #(
  parameter int unsigned TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);

  localparam int unsigned CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] slp_type_i,
  input  logic       slp_go_i,
  input  logic       override_i,
  input  logic       halt_ack_i,
  input  logic       wak_clr_i,
  input  logic       wake_hit_i,
  input  logic       expire_i,
  output seq_st_e    st_o,
  output logic [2:0] tgt_o,
  output logic       halt_req_o,
  output logic       asleep_o,
  output logic [2:0] pwr_state_o,
  output logic       wak_sts_o,
  output logic       resume_o,
  output logic       restart_o,
  output logic       tmo_err_o
);

  seq_st_e    st_q, st_d;
  logic [2:0] tgt_q, tgt_d;
  logic       set_sts, err_set, err_clr;

  always_comb begin
    st_d    = st_q;
    tgt_d   = tgt_q;
    set_sts = 1'b0;
    err_set = 1'b0;
    err_clr = 1'b0;
    unique case (st_q)
      ST_WORK: begin
        if (slp_go_i && type_ok(slp_type_i)) begin
          st_d    = ST_WAIT;
          tgt_d   = slp_type_i;
          err_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (halt_ack_i) begin
          st_d = ST_SLEEP;
        end else if (expire_i) begin
          st_d    = ST_WORK;
          err_set = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_hit_i) begin
          st_d    = ST_EXIT;
          set_sts = 1'b1;
        end
      end
      ST_EXIT: st_d = ST_WORK;
      default: st_d = ST_WORK;
    endcase
    if (override_i) begin
      st_d    = ST_SLEEP;
      tgt_d   = SX_S5;
      set_sts = 1'b0;
      err_set = 1'b0;
      err_clr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_WORK;
      tgt_q       <= '0;
      halt_req_o  <= 1'b0;
      asleep_o    <= 1'b0;
      pwr_state_o <= '0;
      wak_sts_o   <= 1'b0;
      resume_o    <= 1'b0;
      restart_o   <= 1'b0;
      tmo_err_o   <= 1'b0;
    end else begin
      st_q        <= st_d;
      tgt_q       <= tgt_d;
      halt_req_o  <= (st_d == ST_WAIT) || (st_d == ST_SLEEP);
      asleep_o    <= (st_d == ST_SLEEP);
      pwr_state_o <= (st_d == ST_SLEEP) ? tgt_d : 3'd0;
      resume_o    <= (st_d == ST_EXIT) && (tgt_d == SX_S1);
      restart_o   <= (st_d == ST_EXIT) && (tgt_d != SX_S1);
      if (set_sts)        wak_sts_o <= 1'b1;
      else if (wak_clr_i) wak_sts_o <= 1'b0;
      if (err_set)        tmo_err_o <= 1'b1;
      else if (err_clr)   tmo_err_o <= 1'b0;
    end
  end

  assign st_o  = st_q;
  assign tgt_o = tgt_q;

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned NW      = 4,
  parameter int unsigned TMO_CYC = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    slp_type_i,
  input  logic          slp_go_i,
  input  logic [NW-1:0] wake_ev_i,
  input  logic [NW-1:0] wake_en_i,
  input  logic          alarm_i,
  input  logic          alarm_en_i,
  input  logic          alarm_s4_ok_i,
  input  logic          batt_low_i,
  input  logic          override_i,
  input  logic          halt_ack_i,
  input  logic          wak_clr_i,
  output logic          halt_req_o,
  output logic          asleep_o,
  output logic [2:0]    pwr_state_o,
  output logic          wak_sts_o,
  output logic          resume_o,
  output logic          restart_o,
  output logic          tmo_err_o
);

  seq_st_e    st;
  logic [2:0] tgt;
  logic       wake_hit;
  logic       expire;

  sleep_seq_wake #(.NW(NW)) u_wake (
    .wake_ev_i     (wake_ev_i),
    .wake_en_i     (wake_en_i),
    .alarm_i       (alarm_i),
    .alarm_en_i    (alarm_en_i),
    .alarm_s4_ok_i (alarm_s4_ok_i),
    .batt_low_i    (batt_low_i),
    .tgt_i         (tgt),
    .wake_hit_o    (wake_hit)
  );

  sleep_seq_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .run_i    (st == ST_WAIT),
    .expire_o (expire)
  );

  sleep_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .slp_type_i  (slp_type_i),
    .slp_go_i    (slp_go_i),
    .override_i  (override_i),
    .halt_ack_i  (halt_ack_i),
    .wak_clr_i   (wak_clr_i),
    .wake_hit_i  (wake_hit),
    .expire_i    (expire),
    .st_o        (st),
    .tgt_o       (tgt),
    .halt_req_o  (halt_req_o),
    .asleep_o    (asleep_o),
    .pwr_state_o (pwr_state_o),
    .wak_sts_o   (wak_sts_o),
    .resume_o    (resume_o),
    .restart_o   (restart_o),
    .tmo_err_o   (tmo_err_o)
  );

endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int unsigned NW      = 4,
  parameter int unsigned TMO_CYC = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    slp_type_i,
  input logic          slp_go_i,
  input logic [NW-1:0] wake_ev_i,
  input logic [NW-1:0] wake_en_i,
  input logic          override_i,
  input logic          halt_ack_i,
  input logic          wak_clr_i,
  input logic          halt_req_o,
  input logic          asleep_o,
  input logic [2:0]    pwr_state_o,
  input logic          wak_sts_o,
  input logic          resume_o,
  input logic          restart_o
);

  logic working;
  int unsigned wait_cnt;

  assign working = !halt_req_o && !resume_o && !restart_o;

  always_ff @(posedge clk) begin
    if (rst) wait_cnt <= 0;
    else if (halt_req_o && !asleep_o) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end

  // R11: the wait for the halt acknowledgement never exceeds the timeout
  a_r11_wait_bounded: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= TMO_CYC);

  a_r2_go_starts_wait: assert property (@(posedge clk) disable iff (rst)
    (working && slp_go_i && slp_type_i >= 3'd1 && slp_type_i <= 3'd5 && !override_i)
      |=> (halt_req_o && !asleep_o && pwr_state_o == 3'd0));

  a_r3_bad_type_ignored: assert property (@(posedge clk) disable iff (rst)
    (working && slp_go_i && (slp_type_i == 3'd0 || slp_type_i > 3'd5) && !override_i)
      |=> !halt_req_o);

  a_r4_ack_sleeps: assert property (@(posedge clk) disable iff (rst)
    (halt_req_o && !asleep_o && halt_ack_i) |=> asleep_o);

  a_r5_no_early_status: assert property (@(posedge clk) disable iff (rst)
    (!asleep_o && !wak_sts_o) |=> !wak_sts_o);

  a_r6_wake_sets_status: assert property (@(posedge clk) disable iff (rst)
    (asleep_o && (|(wake_ev_i & wake_en_i)) && !override_i) |=> (wak_sts_o && !asleep_o));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
    (resume_o || restart_o) |=> (!resume_o && !restart_o));

  a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> !restart_o);

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
    (wak_sts_o && !wak_clr_i) |=> wak_sts_o);

  a_r9_override_off: assert property (@(posedge clk) disable iff (rst)
    override_i |=> (asleep_o && pwr_state_o == 3'd5 && !resume_o && !restart_o));

endmodule

bind sleep_seq sleep_seq_chk #(.NW(NW), .TMO_CYC(TMO_CYC)) u_chk (.*);

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;

  localparam int NW  = 4;
  localparam int TMO = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    slp_type_i = '0;
  logic          slp_go_i = 1'b0;
  logic [NW-1:0] wake_ev_i = '0;
  logic [NW-1:0] wake_en_i = '0;
  logic          alarm_i = 1'b0, alarm_en_i = 1'b0, alarm_s4_ok_i = 1'b0, batt_low_i = 1'b0;
  logic          override_i = 1'b0, halt_ack_i = 1'b0, wak_clr_i = 1'b0;
  logic          halt_req_o, asleep_o, wak_sts_o, resume_o, restart_o, tmo_err_o;
  logic [2:0]    pwr_state_o;

  sleep_seq #(.NW(NW), .TMO_CYC(TMO)) u_sleep_seq (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  // bench model: 0 working, 1 waiting, 2 asleep, 3 exit
  int m_st = 0, m_tc = 0;
  logic [2:0] m_tgt = '0;
  logic m_sts = 1'b0, m_err = 1'b0;

  function automatic logic exp_hit();
    logic depth_ok;
    depth_ok = (m_tgt >= 1 && m_tgt <= 3) || (m_tgt == 4 && alarm_s4_ok_i);
    return (|(wake_ev_i & wake_en_i)) || (alarm_i && alarm_en_i && !batt_low_i && depth_ok);
  endfunction

  task automatic chk1(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk1(req, "halt_req", 32'(halt_req_o), 32'(m_st == 1 || m_st == 2));
    chk1(req, "asleep", 32'(asleep_o), 32'(m_st == 2));
    chk1(req, "pwr_state", 32'(pwr_state_o), (m_st == 2) ? 32'(m_tgt) : 32'd0);
    chk1(req, "resume", 32'(resume_o), 32'(m_st == 3 && m_tgt == 1));
    chk1(req, "restart", 32'(restart_o), 32'(m_st == 3 && m_tgt != 1));
    chk1(req, "wak_sts", 32'(wak_sts_o), 32'(m_sts));
    chk1(req, "tmo_err", 32'(tmo_err_o), 32'(m_err));
  endtask

  task automatic cycle(input string req);
    int nst, ntc;
    logic [2:0] ntgt;
    logic nsts, nerr;
    nst = m_st; ntgt = m_tgt; nerr = m_err; ntc = 0;
    nsts = wak_clr_i ? 1'b0 : m_sts;
    case (m_st)
      0: if (slp_go_i && slp_type_i >= 1 && slp_type_i <= 5) begin
           nst = 1; ntgt = slp_type_i; nerr = 1'b0;
         end
      1: if (halt_ack_i) nst = 2;
         else if (m_tc == TMO - 1) begin nst = 0; nerr = 1'b1; end
         else ntc = m_tc + 1;
      2: if (exp_hit()) begin nst = 3; nsts = 1'b1; end
      default: nst = 0;
    endcase
    if (override_i) begin
      nst = 2; ntgt = 3'd5; nerr = m_err; nsts = wak_clr_i ? 1'b0 : m_sts;
    end
    @(posedge clk); #1;
    m_st = nst; m_tgt = ntgt; m_sts = nsts; m_err = nerr; m_tc = ntc;
    compare(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cycle(req);
  endtask

  task automatic go(input logic [2:0] t, input string req);
    slp_type_i = t; slp_go_i = 1'b1; cycle(req); slp_go_i = 1'b0;
  endtask

  task automatic ack(input string req);
    halt_ack_i = 1'b1; cycle(req); halt_ack_i = 1'b0;
  endtask

  task automatic sleep_in(input logic [2:0] t, input string req);
    go(t, req); idle(2, req); ack(req);
  endtask

  task automatic wake0(input string req);
    wake_en_i = 4'b0001; wake_ev_i = 4'b0001; cycle(req); wake_ev_i = '0; cycle(req);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    m_st = 0; m_tgt = '0; m_sts = 1'b0; m_err = 1'b0; m_tc = 0;
    compare("R1");
    rst = 1'b0;
    cycle("R1");

    // R3: unsupported and S0 types ignored
    go(3'd6, "R3"); go(3'd7, "R3"); go(3'd0, "R3"); idle(2, "R3");

    // R2, R5: request S1; wake events during the wait change nothing
    go(3'd1, "R2");
    wake_en_i = '1; wake_ev_i = '1; alarm_i = 1'b1; alarm_en_i = 1'b1;
    idle(3, "R5");
    wake_ev_i = '0; alarm_i = 1'b0;
    go(3'd3, "R3"); // go outside working is ignored
    ack("R4");
    idle(2, "R4");
    // R6: masked source ignored, enabled source wakes; R7 resume pulse
    wake_en_i = 4'b0101; wake_ev_i = 4'b1010; idle(2, "R6");
    wake_ev_i = 4'b0100; cycle("R6"); wake_ev_i = '0;
    idle(2, "R7");
    // R8: status sticky, then cleared by write of 1
    idle(2, "R8");
    wak_clr_i = 1'b1; cycle("R8"); wak_clr_i = 1'b0; idle(1, "R8");

    // R7 restart from S3, R12 re-arm to S2 after wake
    sleep_in(3'd3, "R4"); wake0("R7"); idle(1, "R7");
    sleep_in(3'd2, "R12"); wake0("R12");

    // R8: set beats clear in the same cycle
    sleep_in(3'd1, "R8");
    wak_clr_i = 1'b1; wake_ev_i = 4'b0001; cycle("R8"); wake_ev_i = '0; wak_clr_i = 1'b0;
    idle(2, "R8");
    wak_clr_i = 1'b1; cycle("R8"); wak_clr_i = 1'b0;

    // R10: alarm gating
    wake_en_i = '0; alarm_en_i = 1'b1;
    sleep_in(3'd3, "R10");
    batt_low_i = 1'b1; alarm_i = 1'b1; idle(2, "R10");
    batt_low_i = 1'b0; cycle("R10"); alarm_i = 1'b0; idle(2, "R10");
    sleep_in(3'd4, "R10");
    alarm_s4_ok_i = 1'b0; alarm_i = 1'b1; idle(2, "R10");
    alarm_s4_ok_i = 1'b1; cycle("R10"); alarm_i = 1'b0; idle(2, "R10");
    sleep_in(3'd5, "R10");
    alarm_i = 1'b1; idle(3, "R10"); alarm_i = 1'b0;
    wake0("R6");
    alarm_en_i = 1'b0; alarm_s4_ok_i = 1'b0;

    // R11: timeout then cleared by the next accepted request
    go(3'd2, "R11"); idle(TMO + 2, "R11");
    go(3'd4, "R11"); ack("R11"); wake0("R11");

    // R9: override from working, waiting and asleep
    override_i = 1'b1; cycle("R9"); override_i = 1'b0; idle(1, "R9"); wake0("R9");
    go(3'd1, "R9"); override_i = 1'b1; cycle("R9"); override_i = 1'b0; idle(1, "R9"); wake0("R9");
    sleep_in(3'd2, "R9"); override_i = 1'b1; wake_ev_i = 4'b0001; cycle("R9");
    override_i = 1'b0; wake_ev_i = '0; idle(1, "R9"); wake0("R9");

    // random mix, all requirements
    for (int k = 0; k < 4000; k++) begin
      slp_go_i      = ($urandom % 8) == 0;
      slp_type_i    = 3'($urandom);
      halt_ack_i    = ($urandom % 5) == 0;
      wake_en_i     = NW'($urandom);
      wake_ev_i     = (($urandom % 6) == 0) ? NW'($urandom) : '0;
      alarm_i       = ($urandom % 7) == 0;
      alarm_en_i    = 1'($urandom);
      alarm_s4_ok_i = 1'($urandom);
      batt_low_i    = ($urandom % 4) == 0;
      override_i    = ($urandom % 97) == 0;
      wak_clr_i     = ($urandom % 9) == 0;
      cycle("R6 R7 R8 R11 random");
    end
    slp_go_i = 1'b0; halt_ack_i = 1'b0; wake_ev_i = '0; alarm_i = 1'b0;
    override_i = 1'b0; wak_clr_i = 1'b0;
    idle(2, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule